// File: doc/BRIEF.md
# Watchdog Timer with Selectable Period

This block is a watchdog that runs directly from the system clock. A free-running binary prescaler of `STAGES` bits counts one step per clock while the watchdog is enabled. A 3-bit select field picks one of six power-of-two terminal counts. When the count reaches its terminal count, the block signals a timeout. A mode bit decides what the timeout does. It either raises a one-cycle interrupt request, or it drives an internal reset pulse of fixed length.

Software configures the block through a plain write port that carries the enable, select and mode fields. It keeps the system alive by writing a fixed clear code to a command port, and that write restarts the timeout. All pins are plain control and status signals. There is no data stream and no back-pressure.

Let B = `STAGES` - 10, so B = 15 with the default `STAGES` of 25. The timeout period is then P(sel) = 2^(B + 2*sel) clocks.

Top module: `wdog_timer`

## Requirements
- R1: With the block enabled, select values 0..5 give a timeout of 2^(B+2*sel) clocks. With the default settings that is 2^15, 2^17, 2^19, 2^21, 2^23 and 2^25. The timeout event appears at the output exactly P clock edges after the edge that last cleared the count.
- R2: Select values 6 and 7 are reserved and give the same period as select 5.
- R3: With `cfg_mode` = 0, each timeout drives `wdt_irq` high for exactly one cycle, and `wdt_rst` stays low.
- R4: After a timeout the count wraps to zero and keeps running, so the next timeout follows P clocks later.
- R5: A command write with `cmd_code` = 8'h4E clears the count, and the next timeout comes P edges after that write.
- R6: A command write with any other code has no effect on the pending timeout.
- R7: Every accepted configuration write clears the count. As a result, switching to a shorter period does not fire at once.
- R8: With `cfg_enable` = 0, the count holds at zero and neither output is ever asserted.
- R9: With `cfg_mode` = 1, a timeout drives `wdt_rst` high for exactly `RST_CYC` cycles (32 by default), and `wdt_irq` stays low.
- R10: While `wdt_rst` is high, the count is held at zero and every configuration or command write is ignored. Counting resumes when the pulse ends, so the next timeout follows P edges after `wdt_rst` falls.
- R11: After `rst_n` the block is disabled, with select 0 and mode 0, and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the prescaler counts on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration fields |
| cfg_enable | input | 1 | Enable value to write (1 = counting) |
| cfg_sel | input | 3 | Period select value to write |
| cfg_mode | input | 1 | Timeout action to write (0 = interrupt, 1 = reset pulse) |
| cmd_we | input | 1 | Write strobe for the command port |
| cmd_code | input | 8 | Command value; 8'h4E restarts the timeout |
| wdt_irq | output | 1 | One-cycle timeout interrupt request |
| wdt_rst | output | 1 | Internal reset pulse, `RST_CYC` cycles long |

## Verification
A wrong prescaler count, a wrong tap choice or a clear that fails to take effect does not show right away. It shows only as a timeout edge that arrives at the wrong cycle, and that can be up to a full period after the fault. The bench therefore measures the exact edge count from each clearing write to the output edge. A stretch counter that is off by one shows as a reset pulse of the wrong length, or as a shifted restart gap after the pulse falls. A lock that lets writes through during the pulse shows as a missing second reset.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned N_TAPS  = 6;
  localparam int unsigned CODE_W  = 8;
  localparam logic [CODE_W-1:0] WDOG_KICK_CODE = 8'h4E;

  typedef enum logic {
    ACT_IRQ   = 1'b0,
    ACT_RESET = 1'b1
  } wd_action_e;

  // Reserved select codes collapse onto the longest tap.
  function automatic logic [SEL_W-1:0] clamp_sel(input logic [SEL_W-1:0] s);
    return (s > SEL_W'(N_TAPS - 1)) ? SEL_W'(N_TAPS - 1) : s;
  endfunction
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int unsigned STAGES = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              clear,
  output logic [STAGES-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (clear || !run)
      cnt <= '0;
    else
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/wdog_tap_match.sv
module wdog_tap_match
  import wdog_pkg::*;
#(
  parameter int unsigned STAGES = 25
) (
  input  logic [STAGES-1:0] cnt,
  input  logic [SEL_W-1:0]  sel,
  output logic              hit
);
  localparam int unsigned BASE = STAGES - 2 * (N_TAPS - 1);

  logic [N_TAPS-1:0] term;

  // Tap k reaches its terminal count when the low BASE+2k bits are all ones.
  for (genvar k = 0; k < N_TAPS; k++) begin : g_tap
    localparam int unsigned W = BASE + 2 * k;
    assign term[k] = &cnt[W-1:0];
  end

  logic [SEL_W-1:0] sel_eff;
  assign sel_eff = clamp_sel(sel);
  assign hit     = term[sel_eff];
endmodule

// File: rtl/wdog_rst_stretch.sv
module wdog_rst_stretch #(
  parameter int unsigned RST_CYC = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic active
);
  localparam int unsigned CW = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;

  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      left   <= '0;
    end else if (fire) begin
      active <= 1'b1;
      left   <= CW'(RST_CYC - 1);
    end else if (active) begin
      if (left == '0)
        active <= 1'b0;
      else
        left <= left - 1'b1;
    end
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int unsigned STAGES  = 25,
  parameter int unsigned RST_CYC = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_enable,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic              cfg_mode,
  input  logic              cmd_we,
  input  logic [CODE_W-1:0] cmd_code,
  output logic              wdt_irq,
  output logic              wdt_rst
);
  logic              en_q;
  logic [SEL_W-1:0]  sel_q;
  wd_action_e        mode_q;
  logic [STAGES-1:0] cnt;
  logic              hit;
  logic              rst_busy;
  logic              cfg_acc, kick_acc, wr_clear, overflow;

  // Writes are locked out while the reset pulse runs.
  assign cfg_acc  = cfg_we && !rst_busy;
  assign kick_acc = cmd_we && !rst_busy && (cmd_code == WDOG_KICK_CODE);
  assign wr_clear = cfg_acc || kick_acc;
  assign overflow = en_q && hit && !rst_busy && !wr_clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      sel_q  <= '0;
      mode_q <= ACT_IRQ;
    end else if (cfg_acc) begin
      en_q   <= cfg_enable;
      sel_q  <= cfg_sel;
      mode_q <= wd_action_e'(cfg_mode);
    end
  end

  wdog_prescaler #(.STAGES(STAGES)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (en_q),
    .clear (wr_clear || overflow || rst_busy),
    .cnt   (cnt)
  );

  wdog_tap_match #(.STAGES(STAGES)) u_tap (
    .cnt (cnt),
    .sel (sel_q),
    .hit (hit)
  );

  wdog_rst_stretch #(.RST_CYC(RST_CYC)) u_str (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (overflow && (mode_q == ACT_RESET)),
    .active (rst_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      wdt_irq <= 1'b0;
    else
      wdt_irq <= overflow && (mode_q == ACT_IRQ);
  end

  assign wdt_rst = rst_busy;
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
  parameter int unsigned STAGES  = 25,
  parameter int unsigned RST_CYC = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_o,
  input logic              rst_o,
  input logic              en_q,
  input logic              mode_q,
  input logic [STAGES-1:0] cnt
);
  localparam int unsigned HW = $clog2(RST_CYC + 1) + 1;
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_cnt <= '0;
    else if (rst_o) hi_cnt <= hi_cnt + 1'b1;
    else            hi_cnt <= '0;
  end

  a_r3_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);
  a_r3_irq_not_with_rst: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_o && rst_o));
  a_r3_irq_needs_irq_mode: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> !mode_q);
  a_r9_rst_not_too_long: assert property (@(posedge clk) disable iff (!rst_n)
    rst_o |-> (hi_cnt < HW'(RST_CYC)));
  a_r9_rst_full_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_o) |-> (hi_cnt == HW'(RST_CYC)));
  a_r10_count_held: assert property (@(posedge clk) disable iff (!rst_n)
    rst_o |-> (cnt == '0));
  a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !rst_o) |-> (!irq_o && cnt == '0));
endmodule

bind wdog_timer wdog_timer_chk #(.STAGES(STAGES), .RST_CYC(RST_CYC)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .irq_o  (wdt_irq),
  .rst_o  (wdt_rst),
  .en_q   (en_q),
  .mode_q (mode_q),
  .cnt    (cnt)
);

// File: tb/sim_wdog_timer.sv
`timescale 1ns/1ps
module sim_wdog_timer;
  localparam int STAGES  = 13;   // taps 2^3 .. 2^13 keep runs short
  localparam int RST_CYC = 32;
  localparam int NV = 8;
  localparam int VSEL [NV] = '{0, 1, 2, 3, 4, 5, 6, 7};
  localparam int VEXP [NV] = '{8, 32, 128, 512, 2048, 8192, 8192, 8192};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0, cfg_enable = 1'b0, cfg_mode = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic       cmd_we = 1'b0;
  logic [7:0] cmd_code = '0;
  logic       wdt_irq, wdt_rst;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  wdog_timer #(.STAGES(STAGES), .RST_CYC(RST_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_enable(cfg_enable),
    .cfg_sel(cfg_sel), .cfg_mode(cfg_mode), .cmd_we(cmd_we),
    .cmd_code(cmd_code), .wdt_irq(wdt_irq), .wdt_rst(wdt_rst)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    cfg_we = 1'b0; cmd_we = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Called at a negedge; the write lands on the next posedge; returns at the following negedge.
  task automatic cfg_write(input logic en, input int sel, input logic mode);
    cfg_we = 1'b1; cfg_enable = en; cfg_sel = 3'(sel); cfg_mode = mode;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic cmd_write(input logic [7:0] code);
    cmd_we = 1'b1; cmd_code = code;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  // Count posedges until the chosen output is high; other output is watched.
  task automatic wait_high(input bit use_rst, input int limit, output int n, output int other_seen);
    n = 0; other_seen = 0;
    forever begin
      @(posedge clk); #1;
      n++;
      if ((use_rst ? wdt_irq : wdt_rst) == 1'b1) other_seen = 1;
      if ((use_rst ? wdt_rst : wdt_irq) == 1'b1) break;
      if (n > limit) break;
    end
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n, other, len, seen;
    do_reset();
    // R11: reset state and no activity without configuration
    check("R11 irq after reset", int'(wdt_irq), 0);
    check("R11 rst after reset", int'(wdt_rst), 0);
    seen = 0;
    repeat (100) begin @(posedge clk); #1; if (wdt_irq || wdt_rst) seen = 1; end
    check("R11 idle after reset", seen, 0);

    // R1 R2: period vectors
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cfg_write(1'b1, VSEL[i], 1'b0);
      wait_high(1'b0, VEXP[i] + 4, n, other);
      check(VSEL[i] > 5 ? "R2 reserved select period" : "R1 select period", n, VEXP[i]);
    end

    // R3 R4: single-cycle pulse and wrap
    do_reset();
    cfg_write(1'b1, 0, 1'b0);
    wait_high(1'b0, 20, n, other);
    check("R1 first period sel0", n, 8);
    @(posedge clk); #1;
    check("R3 irq one cycle", int'(wdt_irq), 0);
    wait_high(1'b0, 20, n, other);
    check("R4 wrap period", n + 1, 8);
    check("R3 no rst in irq mode", other, 0);

    // R8: disabled
    do_reset();
    cfg_write(1'b0, 0, 1'b0);
    seen = 0;
    repeat (200) begin @(posedge clk); #1; if (wdt_irq || wdt_rst) seen = 1; end
    check("R8 disabled quiet", seen, 0);

    // R5: clear code restarts
    do_reset();
    cfg_write(1'b1, 1, 1'b0);
    repeat (20) @(negedge clk);
    cmd_write(8'h4E);
    wait_high(1'b0, 40, n, other);
    check("R5 kick restarts period", n, 32);

    // R6: wrong code ignored (cfg edge E0, cmd edge E21, timeout E32)
    do_reset();
    cfg_write(1'b1, 1, 1'b0);
    repeat (20) @(negedge clk);
    cmd_write(8'h4D);
    wait_high(1'b0, 40, n, other);
    check("R6 wrong code ignored", n, 32 - 21);

    // R7: select change clears
    do_reset();
    cfg_write(1'b1, 2, 1'b0);
    repeat (50) @(negedge clk);
    cfg_write(1'b1, 0, 1'b0);
    wait_high(1'b0, 20, n, other);
    check("R7 select change clears", n, 8);

    // R9 R10: reset mode
    do_reset();
    cfg_write(1'b1, 0, 1'b1);
    wait_high(1'b1, 20, n, other);
    check("R9 reset timeout", n, 8);
    check("R9 no irq in reset mode", other, 0);
    len = 1; seen = 0;
    forever begin
      @(posedge clk); #1;
      if (len == 3) begin cfg_we = 1'b1; cfg_enable = 1'b0; cfg_mode = 1'b0; cmd_we = 1'b1; cmd_code = 8'h4E; end
      if (len == 4) begin cfg_we = 1'b0; cmd_we = 1'b0; end
      if (wdt_irq) seen = 1;
      if (!wdt_rst) break;
      len++;
      if (len > 100) break;
    end
    cfg_we = 1'b0; cmd_we = 1'b0;
    check("R9 pulse length", len, RST_CYC);
    check("R9 no irq during pulse", seen, 0);
    wait_high(1'b1, 20, n, other);
    check("R10 writes ignored, restart gap", n, 8);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule